// File: doc/BRIEF.md
# Nine-Level Cascaded H-Bridge PWM Modulator

This block is the digital modulator for one phase of an inverter built from four H-bridge cells in series. Every clock it takes a signed sampled reference and an unsigned modulation index. It scales the reference by the index and compares the result against eight triangular carriers, each confined to its own amplitude band. The number of carriers the reference lies above gives a signed output level from -4 to +4. That level is registered and decoded into the sixteen gate drives of the four cells.

A two-bit mode input sets the relative phase of the carriers. In phase disposition every band uses the same triangle. In phase opposition disposition the bands below zero use the inverted triangle. In alternate phase opposition disposition the triangle alternates from one band to the next. A mode change only takes effect at a carrier period boundary, so a carrier period never contains two arrangements.

Top module: `cascade_pwm_mod`

## Requirements
- R1: While the synchronous reset is high, and on the first clock after it, `level_o` is 0 and every cell shows the zero pattern.
- R2: One clock after a rising edge, `level_o` equals the number of carriers that the scaled reference strictly exceeds, minus `NUM_CELLS`. The carriers are the values the carriers had in the cycle before that edge.
- R3: A shared triangle counter starts at 0 after reset. It rises by 1 per clock up to `BAND` and then falls by 1 per clock back to 0, for a period of 2*`BAND` clocks. Carrier k (k = 0 for the lowest band) equals (k - `NUM_CELLS`)*`BAND` plus a shape value, and the shape value is either the triangle t or `BAND` - t.
- R4: Mode code 0 (phase disposition) uses shape t for every carrier. Code 3 behaves like code 0.
- R5: Mode code 1 (phase opposition) uses shape t for carriers k >= `NUM_CELLS` and `BAND` - t for the carriers below zero.
- R6: Mode code 2 (alternate opposition) uses shape t for even k and `BAND` - t for odd k.
- R7: `mode_i` is taken only in a cycle where the triangle is 0, and it is used in that same cycle. In every other cycle the mode taken last is used. After reset the mode in use is code 0.
- R8: The scaled reference is floor(`ref_i` * `mod_idx_i` / 2^`IDX_FRAC`). It is clamped to the range -`NUM_CELLS`*`BAND` .. +`NUM_CELLS`*`BAND`. An index of 2^`IDX_FRAC` is unity gain.
- R9: Cell c drives `gates_o[4c+3:4c]`. Bit 0 is the first-leg upper switch, bit 1 the first-leg lower, bit 2 the second-leg upper and bit 3 the second-leg lower. A positive cell is 4'b1001, a negative cell is 4'b0110, and a zero cell is 4'b0101.
- R10: For level L > 0, cells 0..L-1 are positive and the rest are zero. For L < 0, cells 0..|L|-1 are negative and the rest are zero. As the magnitude falls, the highest-numbered active cell is the first to return to zero.
- R11: `level_o` stays within ±`NUM_CELLS` and always equals the count of positive cells minus the count of negative cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ref_i | input | REF_W | Signed reference sample |
| mod_idx_i | input | IDX_W | Unsigned modulation index, unity at 2^IDX_FRAC |
| mode_i | input | 2 | Carrier arrangement: 0 PD, 1 POD, 2 APOD, 3 as PD |
| level_o | output | LVL_W | Signed output level |
| gates_o | output | 4*NUM_CELLS | Gate drives, four per cell |

## Verification
The hardest case to reach from the ports is a mode request that arrives in the middle of a carrier period. The old arrangement must stay in force until the triangle returns to zero, and the new one must apply in that boundary cycle. The bench changes `mode_i` at cycles well away from the boundary and keeps driving references that lie between the two candidate carriers. In that region the two arrangements give different levels, so an early or late switch shows up in `level_o`. Random references with random indices, including zero, saturating and above-unity gains, cover the clamp and every band.

// File: rtl/cascade_pwm_pkg.sv
package cascade_pwm_pkg;

    typedef enum logic [1:0] {
        MODE_PD   = 2'd0,
        MODE_POD  = 2'd1,
        MODE_APOD = 2'd2,
        MODE_ALT  = 2'd3
    } carrier_mode_e;

    localparam logic [3:0] CELL_POS  = 4'b1001;
    localparam logic [3:0] CELL_NEG  = 4'b0110;
    localparam logic [3:0] CELL_ZERO = 4'b0101;

endpackage

// File: rtl/pwm_carrier_bank.sv
module pwm_carrier_bank
    import cascade_pwm_pkg::*;
#(
    parameter int NUM_CELLS = 4,
    parameter int BAND      = 16,
    parameter int REF_W     = 12,
    localparam int NCAR     = 2 * NUM_CELLS,
    localparam int TW       = $clog2(BAND + 1)
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic [1:0]                 mode_i,
    output logic [NCAR-1:0][REF_W-1:0] carriers_o,
    output logic [TW-1:0]              tri_o,
    output logic [1:0]                 mode_o
);

    typedef struct packed {
        logic [TW-1:0] tri_cnt;
        logic          rising;
        logic [1:0]    mode;
    } bank_state_t;

    localparam logic [TW-1:0] TOP = TW'(BAND);

    bank_state_t st_d, st_q;
    logic [1:0]    mode_use;
    logic [TW-1:0] inv_tri;

    always_comb begin
        st_d     = st_q;
        mode_use = (st_q.tri_cnt == '0) ? mode_i : st_q.mode;
        st_d.mode = mode_use;
        if (st_q.rising) begin
            st_d.tri_cnt = st_q.tri_cnt + 1'b1;
            st_d.rising  = (st_q.tri_cnt + 1'b1) != TOP;
        end else begin
            st_d.tri_cnt = st_q.tri_cnt - 1'b1;
            st_d.rising  = (st_q.tri_cnt - 1'b1) == '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.tri_cnt <= '0;
            st_q.rising  <= 1'b1;
            st_q.mode    <= MODE_PD;
        end else begin
            st_q <= st_d;
        end
    end

    assign inv_tri = TOP - st_q.tri_cnt;

    for (genvar k = 0; k < NCAR; k++) begin : g_car
        localparam int BASE = (k - NUM_CELLS) * BAND;
        logic          use_inv;
        logic [TW-1:0] shape;
        always_comb begin
            case (mode_use)
                MODE_POD:  use_inv = (k < NUM_CELLS);
                MODE_APOD: use_inv = (k % 2) == 1;
                default:   use_inv = 1'b0;
            endcase
            shape = use_inv ? inv_tri : st_q.tri_cnt;
        end
        assign carriers_o[k] = REF_W'(BASE) + REF_W'(shape);
    end

    assign tri_o  = st_q.tri_cnt;
    assign mode_o = st_q.mode;

endmodule

// File: rtl/pwm_level_cmp.sv
module pwm_level_cmp #(
    parameter int NUM_CELLS = 4,
    parameter int BAND      = 16,
    parameter int REF_W     = 12,
    parameter int IDX_W     = 8,
    parameter int IDX_FRAC  = 7,
    localparam int NCAR     = 2 * NUM_CELLS,
    localparam int LVL_W    = $clog2(NUM_CELLS + 1) + 1,
    localparam int PW       = REF_W + IDX_W + 1,
    localparam int CNT_W    = $clog2(NCAR + 1)
) (
    input  logic signed [REF_W-1:0]    ref_i,
    input  logic [IDX_W-1:0]           idx_i,
    input  logic [NCAR-1:0][REF_W-1:0] carriers_i,
    output logic signed [LVL_W-1:0]    level_o
);

    localparam logic signed [PW-1:0] LIM_HI = PW'(NUM_CELLS * BAND);
    localparam logic signed [PW-1:0] LIM_LO = -LIM_HI;

    logic signed [PW-1:0]    ref_ext, idx_ext, prod, scaled;
    logic signed [REF_W-1:0] eff;
    logic [CNT_W-1:0]        above;

    always_comb begin
        ref_ext = {{(PW-REF_W){ref_i[REF_W-1]}}, ref_i};
        idx_ext = {{(PW-IDX_W){1'b0}}, idx_i};
        prod    = ref_ext * idx_ext;
        scaled  = prod >>> IDX_FRAC;
        if (scaled > LIM_HI)      eff = REF_W'(LIM_HI);
        else if (scaled < LIM_LO) eff = REF_W'(LIM_LO);
        else                      eff = REF_W'(scaled);
        above = '0;
        for (int k = 0; k < NCAR; k++) begin
            if (eff > $signed(carriers_i[k])) above = above + 1'b1;
        end
        level_o = LVL_W'(above) - LVL_W'(NUM_CELLS);
    end

endmodule

// File: rtl/pwm_cell_decode.sv
module pwm_cell_decode
    import cascade_pwm_pkg::*;
#(
    parameter int NUM_CELLS = 4,
    localparam int LVL_W    = $clog2(NUM_CELLS + 1) + 1
) (
    input  logic signed [LVL_W-1:0]  level_i,
    output logic [4*NUM_CELLS-1:0]   gates_o
);

    for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
        localparam logic signed [LVL_W-1:0] POS_TH = LVL_W'(c);
        localparam logic signed [LVL_W-1:0] NEG_TH = -LVL_W'(c);
        always_comb begin
            if (level_i > POS_TH)      gates_o[4*c +: 4] = CELL_POS;
            else if (level_i < NEG_TH) gates_o[4*c +: 4] = CELL_NEG;
            else                       gates_o[4*c +: 4] = CELL_ZERO;
        end
    end

endmodule

// File: rtl/cascade_pwm_mod.sv
module cascade_pwm_mod
    import cascade_pwm_pkg::*;
#(
    parameter int NUM_CELLS = 4,
    parameter int BAND      = 16,
    parameter int REF_W     = 12,
    parameter int IDX_W     = 8,
    parameter int IDX_FRAC  = 7,
    localparam int NCAR     = 2 * NUM_CELLS,
    localparam int LVL_W    = $clog2(NUM_CELLS + 1) + 1,
    localparam int TW       = $clog2(BAND + 1)
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic signed [REF_W-1:0] ref_i,
    input  logic [IDX_W-1:0]        mod_idx_i,
    input  logic [1:0]              mode_i,
    output logic signed [LVL_W-1:0] level_o,
    output logic [4*NUM_CELLS-1:0]  gates_o
);

    typedef struct packed {
        logic signed [LVL_W-1:0] level;
        logic [4*NUM_CELLS-1:0]  gates;
    } out_state_t;

    logic [NCAR-1:0][REF_W-1:0] carriers;
    logic [TW-1:0]              tri_w;
    logic [1:0]                 mode_w;
    logic signed [LVL_W-1:0]    level_c;
    logic [4*NUM_CELLS-1:0]     gates_c;
    out_state_t                 st_d, st_q;

    pwm_carrier_bank #(
        .NUM_CELLS(NUM_CELLS), .BAND(BAND), .REF_W(REF_W)
    ) u_bank (
        .clk_i(clk_i), .rst_i(rst_i), .mode_i(mode_i),
        .carriers_o(carriers), .tri_o(tri_w), .mode_o(mode_w)
    );

    pwm_level_cmp #(
        .NUM_CELLS(NUM_CELLS), .BAND(BAND), .REF_W(REF_W),
        .IDX_W(IDX_W), .IDX_FRAC(IDX_FRAC)
    ) u_cmp (
        .ref_i(ref_i), .idx_i(mod_idx_i), .carriers_i(carriers),
        .level_o(level_c)
    );

    pwm_cell_decode #(
        .NUM_CELLS(NUM_CELLS)
    ) u_dec (
        .level_i(level_c), .gates_o(gates_c)
    );

    always_comb begin
        st_d       = st_q;
        st_d.level = level_c;
        st_d.gates = gates_c;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.level <= '0;
            st_q.gates <= {NUM_CELLS{CELL_ZERO}};
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;
    assign gates_o = st_q.gates;

endmodule

// File: rtl/cascade_pwm_chk.sv
module cascade_pwm_chk
    import cascade_pwm_pkg::*;
#(
    parameter int NUM_CELLS = 4,
    parameter int BAND      = 16,
    localparam int LVL_W    = $clog2(NUM_CELLS + 1) + 1,
    localparam int TW       = $clog2(BAND + 1)
) (
    input logic                    clk_i,
    input logic                    rst_i,
    input logic signed [LVL_W-1:0] level_i,
    input logic [4*NUM_CELLS-1:0]  gates_i,
    input logic [TW-1:0]           tri_i,
    input logic [1:0]              mode_i
);

    function automatic int cell_sum(logic [4*NUM_CELLS-1:0] g);
        int s = 0;
        for (int c = 0; c < NUM_CELLS; c++) begin
            if (g[4*c +: 4] == CELL_POS) s++;
            if (g[4*c +: 4] == CELL_NEG) s--;
        end
        return s;
    endfunction

    // R1: zero state right after a reset cycle
    a_r1_reset_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (level_i == '0 && gates_i == {NUM_CELLS{CELL_ZERO}}));

    // R3: triangle stays within the band and moves by one per clock
    a_r3_tri_step: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> (tri_i <= TW'(BAND)) &&
        ((tri_i == $past(tri_i) + 1'b1) || (tri_i == $past(tri_i) - 1'b1)));

    // R7: mode in use changes only after a boundary cycle
    a_r7_mode_boundary: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(mode_i) |-> $past(tri_i) == '0);

    // R11: level range and agreement with the cell states
    a_r11_level_sum: assert property (@(posedge clk_i) disable iff (rst_i)
        ($signed(level_i) <= NUM_CELLS) && ($signed(level_i) >= -NUM_CELLS) &&
        (int'(level_i) == cell_sum(gates_i)));

    for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell_chk
        // R9: only the three legal patterns appear on a cell
        a_r9_cell_legal: assert property (@(posedge clk_i) disable iff (rst_i)
            (gates_i[4*c +: 4] == CELL_POS) || (gates_i[4*c +: 4] == CELL_NEG) ||
            (gates_i[4*c +: 4] == CELL_ZERO));
        if (c + 1 < NUM_CELLS) begin : g_ord
            // R10: an active higher cell implies the lower cell matches it
            a_r10_drop_order: assert property (@(posedge clk_i) disable iff (rst_i)
                (gates_i[4*(c+1) +: 4] != CELL_ZERO) |->
                (gates_i[4*c +: 4] == gates_i[4*(c+1) +: 4]));
        end
    end

endmodule

bind cascade_pwm_mod cascade_pwm_chk #(
    .NUM_CELLS(NUM_CELLS), .BAND(BAND)
) u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .level_i(level_o), .gates_i(gates_o),
    .tri_i(tri_w), .mode_i(mode_w)
);

// File: tb/sim_cascade_pwm_mod.sv
`timescale 1ns/1ps
module sim_cascade_pwm_mod;

    localparam int NC   = 4;
    localparam int B    = 16;
    localparam int RW   = 12;
    localparam int IW   = 8;
    localparam int FRAC = 7;
    localparam int LW   = $clog2(NC + 1) + 1;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic signed [RW-1:0] ref_s = '0;
    logic [IW-1:0]        idx = 8'd128;
    logic [1:0]           mode = 2'd0;
    logic signed [LW-1:0] level;
    logic [4*NC-1:0]      gates;

    int checks = 0;
    int errors = 0;

    // bench model of the carrier state
    int  m_t = 0;
    bit  m_up = 1'b1;
    int  m_mode = 0;
    bit  have_exp = 1'b0;
    int  exp_lvl = 0;
    logic [4*NC-1:0] exp_gates = '0;
    string exp_tag = "";

    always #2 clk = ~clk;

    cascade_pwm_mod #(.NUM_CELLS(NC), .BAND(B), .REF_W(RW), .IDX_W(IW), .IDX_FRAC(FRAC)) u0 (
        .clk_i(clk), .rst_i(rst), .ref_i(ref_s), .mod_idx_i(idx), .mode_i(mode),
        .level_o(level), .gates_o(gates)
    );

    function automatic int model_level(int r, int i, int md, int t);
        int e = (r * i) >>> FRAC;
        int cnt = 0;
        if (e > NC * B) e = NC * B;
        if (e < -NC * B) e = -NC * B;
        for (int k = 0; k < 2 * NC; k++) begin
            bit inv;
            case (md)
                1: inv = (k < NC);
                2: inv = (k % 2) == 1;
                default: inv = 1'b0;
            endcase
            if (e > (k - NC) * B + (inv ? B - t : t)) cnt++;
        end
        return cnt - NC;
    endfunction

    function automatic logic [4*NC-1:0] model_gates(int l);
        logic [4*NC-1:0] g;
        for (int c = 0; c < NC; c++) begin
            if (l > c)       g[4*c +: 4] = 4'b1001;
            else if (-l > c) g[4*c +: 4] = 4'b0110;
            else             g[4*c +: 4] = 4'b0101;
        end
        return g;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    // called at a falling edge: check last prediction, drive, predict next
    task automatic step(int r, int i, int md, string tag);
        int use_mode;
        if (have_exp) begin
            check(int'(level) == exp_lvl, exp_tag, int'(level), exp_lvl);
            check(gates == exp_gates, "R9 R10 gates", int'(gates), int'(exp_gates));
        end
        ref_s = RW'(r);
        idx   = IW'(i);
        mode  = 2'(md);
        use_mode = (m_t == 0) ? md : m_mode;
        exp_lvl  = model_level(r, i, use_mode, m_t);
        exp_gates = model_gates(exp_lvl);
        exp_tag  = tag;
        have_exp = 1'b1;
        m_mode = use_mode;
        if (m_up) begin
            m_t++;
            m_up = (m_t != B);
        end else begin
            m_t--;
            m_up = (m_t == 0);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        process::self().srandom(32'd12345);
        ref_s = 12'sd500;
        idx = 8'd128;
        repeat (3) @(negedge clk);
        // R1: reset state while held
        check(level == '0, "R1 level", int'(level), 0);
        check(gates == 16'h5555, "R1 gates", int'(gates), 16'h5555);
        rst = 1'b0;

        // R3 R4: PD sweep at unity gain across two periods
        for (int n = 0; n < 4 * B; n++) step(-70 + (n * 140) / (4 * B), 128, 0, "R2 R3 R4 PD");
        // R5: POD, references just under and over zero
        for (int n = 0; n < 4 * B; n++) step((n % 2) ? -(n % B) : (n % B), 128, 1, "R2 R5 POD");
        // R6: APOD
        for (int n = 0; n < 4 * B; n++) step(-60 + n * 2, 128, 2, "R2 R6 APOD");
        // R4: code 3 behaves like PD
        for (int n = 0; n < 2 * B; n++) step(-8 + n, 128, 3, "R4 code3");
        // R7: request a new mode mid-period, reference between candidates
        for (int n = 0; n < 6 * B; n++) begin
            int md = (n < 3) ? 0 : ((n < 2 * B + 5) ? 2 : 1);
            step(-B / 2 + (n % 3), 128, md, "R7 mode boundary");
        end
        // R8: saturation, zero index and above-unity gain
        for (int n = 0; n < B; n++) step(2000, 255, 0, "R8 clamp high");
        for (int n = 0; n < B; n++) step(-2000, 255, 0, "R8 clamp low");
        for (int n = 0; n < B; n++) step(900, 0, 1, "R8 zero index");
        for (int n = 0; n < 2 * B; n++) step(-40 + n, 200, 2, "R8 gain");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int r  = int'($urandom_range(0, 200)) - 100;
            int i  = int'($urandom_range(0, 255));
            int md = int'($urandom_range(0, 3));
            if (n % 7 == 0) i = 128;
            step(r, i, md, "R2 R8 random");
        end
        step(0, 128, 0, "R2 final");

        // R1: reset mid-run returns to zero state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(level == '0, "R1 level again", int'(level), 0);
        check(gates == 16'h5555, "R1 gates again", int'(gates), 16'h5555);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule